// File: doc/BRIEF.md
# DMA Channel Queue Pointer Registers

This block is the pointer register file for a single host-visible DMA channel. The channel pairs two rings that live in host memory. The host posts work into a request ring, and the device returns completions through a response ring. Both rings share one contiguous chunk of host memory. The request ring starts at the chunk base, and the response ring sits at the very end of the chunk.

The block keeps the head and tail index of each ring and decodes host register reads and writes inside the channel's 4 KB window. It gives the device the address of the next request element to fetch and the next response slot to fill. It also turns response posting into coalesced MSI pulses. An MSI is raised only when a post lands in an empty response ring. A request may carry a force flag, and that flag adds an extra MSI when configuration allows it. One instance serves one channel; a bridge with 16 channels instantiates it 16 times, one per 4 KB window.

Top module: `dmach_qptr_regs`

## Requirements
- R1: After a synchronous reset, all four indexes are zero, `msi_pulse` is low, `dev_req_avail` is low and `dev_rsp_ready` is high.
- R2: A host read at window offset 0x0 returns the request head, 0x4 the request tail, 0x8 the response head and 0xC the response tail, each zero-extended to 32 bits. The data and `host_rvalid` appear in the cycle after `host_rd`.
- R3: The host sets the request tail by writing offset 0x4 and the response head by writing offset 0x8. A written value is stored only if it is below `RING_DEPTH`; a larger value is ignored.
- R4: Host writes to 0x0, to 0xC or to any other offset change no index. A read of any window offset other than 0x0, 0x4, 0x8 and 0xC returns zero.
- R5: `dev_req_avail` is high when request head differs from request tail. A `dev_req_take` advances the request head by one only while the ring is non-empty; a take on an empty ring is ignored.
- R6: The response ring is full when tail+1 (modulo depth) equals head, and `dev_rsp_ready` is then low. A `dev_rsp_post` advances the response tail only while the ring is not full; a stalled post changes nothing and raises no MSI.
- R7: `dev_req_addr` equals chunk base plus request head times `2**REQ_ELEM_LG` bytes (64 by default).
- R8: `dev_rsp_addr` equals chunk base plus `CHUNK_BYTES` minus `RING_DEPTH * 2**RSP_ELEM_LG`, plus response tail times `2**RSP_ELEM_LG` bytes (4 by default).
- R9: An accepted post into an empty response ring gives a one-cycle `msi_pulse` in the next cycle. An accepted post into a non-empty ring gives none, unless R10 applies.
- R10: An accepted post with `dev_rsp_force` high gives an `msi_pulse` whatever the ring state, but only while `cfg_force_msi_en` is high.
- R11: Device-advanced indexes wrap from `RING_DEPTH-1` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_chunk_base | input | ADDR_W | Host address of the chunk holding both rings |
| cfg_force_msi_en | input | 1 | Honour the per-request force-MSI flag |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | 12 | Byte offset within the channel window |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered read data |
| host_rvalid | output | 1 | Read data valid, one cycle after `host_rd` |
| dev_req_avail | output | 1 | Request ring holds at least one element |
| dev_req_addr | output | ADDR_W | Address of the request element at the head |
| dev_req_take | input | 1 | Device consumed the head request |
| dev_rsp_ready | output | 1 | Response ring has a free slot |
| dev_rsp_addr | output | ADDR_W | Address of the response slot at the tail |
| dev_rsp_post | input | 1 | Device wrote a response element at the tail |
| dev_rsp_force | input | 1 | Force-MSI flag of the request being completed |
| msi_pulse | output | 1 | One-cycle MSI request |

## Verification
The assertions assume that `host_rd` and `host_wr` are never high in the same cycle. They also assume that a take or a post is a single-cycle strobe issued at most once per cycle. The take and post strobes are checked against the ring state of the same cycle, so the assertions need no ordering between the host and device ports. The directed stimulus drives each strobe for exactly one cycle from a falling edge. It keeps host and device activity in separate cycles, so the expected index trace can be computed step by step. The stimulus deliberately drives takes on an empty request ring and posts on a full response ring, because those are the conditions the guarding assertions are meant to see.

// File: rtl/dmach_qptr_pkg.sv
package dmach_qptr_pkg;
  localparam int WIN_AW = 12;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    SEL_REQ_HEAD = 2'd0,
    SEL_REQ_TAIL = 2'd1,
    SEL_RSP_HEAD = 2'd2,
    SEL_RSP_TAIL = 2'd3
  } qsel_e;
endpackage

// File: rtl/dmach_qptr_ring.sv
module dmach_qptr_ring #(
  parameter int RING_DEPTH     = 8,
  parameter int IDX_W          = 3,
  parameter bit HOST_SIDE_TAIL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_we,
  input  logic [31:0]      host_wval,
  input  logic             dev_adv,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic             empty,
  output logic             full,
  output logic             adv_done
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(RING_DEPTH - 1);

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] v);
    return (v == LAST) ? '0 : v + 1'b1;
  endfunction

  logic host_ok;
  logic [IDX_W-1:0] adv_ptr;

  assign host_ok = host_we && (host_wval < 32'(RING_DEPTH));
  assign empty   = (head == tail);
  assign full    = (step(tail) == head);

  generate
    if (HOST_SIDE_TAIL) begin : g_host_tail
      assign adv_done = dev_adv && !empty;
      assign adv_ptr  = head;
      always_ff @(posedge clk) begin
        if (rst) begin
          head <= '0;
          tail <= '0;
        end else begin
          if (host_ok)  tail <= host_wval[IDX_W-1:0];
          if (adv_done) head <= step(head);
        end
      end
      p_take_blocked_r5: assert property (@(posedge clk) disable iff (rst)
        (dev_adv && empty) |=> $stable(head));
    end else begin : g_host_head
      assign adv_done = dev_adv && !full;
      assign adv_ptr  = tail;
      always_ff @(posedge clk) begin
        if (rst) begin
          head <= '0;
          tail <= '0;
        end else begin
          if (host_ok)  head <= host_wval[IDX_W-1:0];
          if (adv_done) tail <= step(tail);
        end
      end
      p_post_stalled_r6: assert property (@(posedge clk) disable iff (rst)
        (dev_adv && full) |=> $stable(tail));
    end
  endgenerate

  p_wrap_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (adv_done && adv_ptr == LAST) |=> (adv_ptr == '0));
endmodule

// File: rtl/dmach_qptr_decode.sv
module dmach_qptr_decode
  import dmach_qptr_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [WIN_AW-1:0] host_addr,
  input  logic [IDX_W-1:0]  req_head,
  input  logic [IDX_W-1:0]  req_tail,
  input  logic [IDX_W-1:0]  rsp_head,
  input  logic [IDX_W-1:0]  rsp_tail,
  output logic              wr_req_tail,
  output logic              wr_rsp_head,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid
);
  logic  hit;
  qsel_e sel;
  logic [DATA_W-1:0] rd_mux;

  assign hit = (host_addr[WIN_AW-1:4] == '0) && (host_addr[1:0] == 2'b00);
  assign sel = qsel_e'(host_addr[3:2]);

  assign wr_req_tail = host_wr && hit && (sel == SEL_REQ_TAIL);
  assign wr_rsp_head = host_wr && hit && (sel == SEL_RSP_HEAD);

  always_comb begin
    rd_mux = '0;
    if (hit) begin
      unique case (sel)
        SEL_REQ_HEAD: rd_mux = DATA_W'(req_head);
        SEL_REQ_TAIL: rd_mux = DATA_W'(req_tail);
        SEL_RSP_HEAD: rd_mux = DATA_W'(rsp_head);
        SEL_RSP_TAIL: rd_mux = DATA_W'(rsp_tail);
        default:      rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= host_rd;
      if (host_rd) host_rdata <= rd_mux;
    end
  end

  p_read_latency_r2: assert property (@(posedge clk) disable iff (rst)
    host_rd |=> host_rvalid);
endmodule

// File: rtl/dmach_qptr_msi.sv
module dmach_qptr_msi (
  input  logic clk,
  input  logic rst,
  input  logic post_done,
  input  logic was_empty,
  input  logic force_req,
  input  logic force_en,
  output logic msi_pulse
);
  logic fire;
  assign fire = post_done && (was_empty || (force_req && force_en));

  always_ff @(posedge clk) begin
    if (rst) msi_pulse <= 1'b0;
    else     msi_pulse <= fire;
  end

  p_msi_needs_post_r9: assert property (@(posedge clk) disable iff (rst)
    msi_pulse |-> $past(post_done));
  p_quiet_nonempty_r10: assert property (@(posedge clk) disable iff (rst)
    (post_done && !was_empty && !(force_req && force_en)) |=> !msi_pulse);
endmodule

// File: rtl/dmach_qptr_regs.sv
module dmach_qptr_regs
  import dmach_qptr_pkg::*;
#(
  parameter int RING_DEPTH  = 8,
  parameter int ADDR_W      = 64,
  parameter int REQ_ELEM_LG = 6,
  parameter int RSP_ELEM_LG = 2,
  parameter int CHUNK_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_chunk_base,
  input  logic              cfg_force_msi_en,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [11:0]       host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              host_rvalid,
  output logic              dev_req_avail,
  output logic [ADDR_W-1:0] dev_req_addr,
  input  logic              dev_req_take,
  output logic              dev_rsp_ready,
  output logic [ADDR_W-1:0] dev_rsp_addr,
  input  logic              dev_rsp_post,
  input  logic              dev_rsp_force,
  output logic              msi_pulse
);
  localparam int IDX_W   = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1;
  localparam int RSP_OFS = CHUNK_BYTES - RING_DEPTH * (1 << RSP_ELEM_LG);

  logic [IDX_W-1:0] req_head, req_tail, rsp_head, rsp_tail;
  logic req_empty, req_full, rsp_empty, rsp_full;
  logic req_adv, rsp_adv;
  logic wr_req_tail, wr_rsp_head;

  dmach_qptr_decode #(.IDX_W(IDX_W)) u_dec (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .req_head(req_head), .req_tail(req_tail),
    .rsp_head(rsp_head), .rsp_tail(rsp_tail), .wr_req_tail(wr_req_tail),
    .wr_rsp_head(wr_rsp_head), .host_rdata(host_rdata), .host_rvalid(host_rvalid)
  );

  dmach_qptr_ring #(.RING_DEPTH(RING_DEPTH), .IDX_W(IDX_W), .HOST_SIDE_TAIL(1'b1)) u_req (
    .clk(clk), .rst(rst), .host_we(wr_req_tail), .host_wval(host_wdata),
    .dev_adv(dev_req_take), .head(req_head), .tail(req_tail),
    .empty(req_empty), .full(req_full), .adv_done(req_adv)
  );

  dmach_qptr_ring #(.RING_DEPTH(RING_DEPTH), .IDX_W(IDX_W), .HOST_SIDE_TAIL(1'b0)) u_rsp (
    .clk(clk), .rst(rst), .host_we(wr_rsp_head), .host_wval(host_wdata),
    .dev_adv(dev_rsp_post), .head(rsp_head), .tail(rsp_tail),
    .empty(rsp_empty), .full(rsp_full), .adv_done(rsp_adv)
  );

  dmach_qptr_msi u_msi (
    .clk(clk), .rst(rst), .post_done(rsp_adv), .was_empty(rsp_empty),
    .force_req(dev_rsp_force), .force_en(cfg_force_msi_en), .msi_pulse(msi_pulse)
  );

  assign dev_req_avail = !req_empty;
  assign dev_rsp_ready = !rsp_full;
  assign dev_req_addr  = cfg_chunk_base + (ADDR_W'(req_head) << REQ_ELEM_LG);
  assign dev_rsp_addr  = cfg_chunk_base + ADDR_W'(RSP_OFS) + (ADDR_W'(rsp_tail) << RSP_ELEM_LG);

  logic unused_full;
  assign unused_full = req_full;
endmodule

// File: tb/dmach_qptr_regs_test.sv
module dmach_qptr_regs_test;
  localparam logic [63:0] BASE    = 64'h0000_0012_3400_0000;
  localparam logic [63:0] RSPBASE = BASE + 64'd4064;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [63:0] cfg_chunk_base = BASE;
  logic cfg_force_msi_en = 1'b0;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [11:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic host_rvalid, dev_req_avail, dev_rsp_ready, msi_pulse;
  logic [63:0] dev_req_addr, dev_rsp_addr;
  logic dev_req_take = 1'b0, dev_rsp_post = 1'b0, dev_rsp_force = 1'b0;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dmach_qptr_regs uut (
    .clk(clk), .rst(rst), .cfg_chunk_base(cfg_chunk_base), .cfg_force_msi_en(cfg_force_msi_en),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid), .dev_req_avail(dev_req_avail),
    .dev_req_addr(dev_req_addr), .dev_req_take(dev_req_take), .dev_rsp_ready(dev_rsp_ready),
    .dev_rsp_addr(dev_rsp_addr), .dev_rsp_post(dev_rsp_post), .dev_rsp_force(dev_rsp_force),
    .msi_pulse(msi_pulse)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [11:0] a, input logic [31:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [11:0] a, input logic [31:0] exp, input string req);
    host_rd = 1'b1; host_addr = a;
    @(posedge clk); @(negedge clk);
    host_rd = 1'b0;
    chk(host_rvalid === 1'b1, "R2 rvalid", 64'(host_rvalid), 64'd1);
    chk(host_rdata === exp, req, 64'(host_rdata), 64'(exp));
  endtask

  task automatic take();
    dev_req_take = 1'b1;
    @(posedge clk); @(negedge clk);
    dev_req_take = 1'b0;
  endtask

  task automatic post(input bit f, input bit exp_msi, input string req);
    dev_rsp_post = 1'b1; dev_rsp_force = f;
    @(posedge clk); @(negedge clk);
    dev_rsp_post = 1'b0; dev_rsp_force = 1'b0;
    chk(msi_pulse === exp_msi, req, 64'(msi_pulse), 64'(exp_msi));
  endtask

  task automatic t_reset();
    chk(msi_pulse === 1'b0, "R1 msi", 64'(msi_pulse), 0);
    chk(dev_req_avail === 1'b0, "R1 avail", 64'(dev_req_avail), 0);
    chk(dev_rsp_ready === 1'b1, "R1 ready", 64'(dev_rsp_ready), 1);
    hread(12'h0, 0, "R1 req head");
    hread(12'h4, 0, "R1 req tail");
    hread(12'h8, 0, "R1 rsp head");
    hread(12'hC, 0, "R1 rsp tail");
  endtask

  task automatic t_host_write();
    hwrite(12'h4, 5);
    hread(12'h4, 5, "R3 req tail write");
    hwrite(12'h4, 9);
    hread(12'h4, 5, "R3 out-of-range tail ignored");
    hwrite(12'h8, 12);
    hread(12'h8, 0, "R3 out-of-range head ignored");
  endtask

  task automatic t_ro_write();
    hwrite(12'h0, 2);
    hwrite(12'hC, 2);
    hwrite(12'h10, 7);
    hread(12'h0, 0, "R4 req head read-only");
    hread(12'hC, 0, "R4 rsp tail read-only");
    hread(12'h4, 5, "R4 unmapped write no effect");
    hread(12'h10, 0, "R4 unmapped read zero");
    hread(12'h7FC, 0, "R4 high unmapped read zero");
    hread(12'h6, 0, "R4 misaligned read zero");
  endtask

  task automatic t_req_consume();
    chk(dev_req_avail === 1'b1, "R5 avail", 64'(dev_req_avail), 1);
    chk(dev_req_addr === BASE, "R7 addr idx0", dev_req_addr, BASE);
    take(); take();
    chk(dev_req_addr === BASE + 64'd128, "R7 addr idx2", dev_req_addr, BASE + 64'd128);
    take(); take(); take();
    chk(dev_req_avail === 1'b0, "R5 empty after drain", 64'(dev_req_avail), 0);
    take();
    hread(12'h0, 5, "R5 take on empty ignored");
    hwrite(12'h4, 1);
    for (int i = 0; i < 3; i++) take();
    chk(dev_req_addr === BASE, "R11 req head wrapped to 0", dev_req_addr, BASE);
    take();
    hread(12'h0, 1, "R11 req head after wrap");
    chk(dev_req_avail === 1'b0, "R5 empty after wrap", 64'(dev_req_avail), 0);
  endtask

  task automatic t_rsp_msi();
    post(1'b0, 1'b1, "R9 msi on empty-to-nonempty");
    chk(dev_rsp_addr === RSPBASE + 64'd4, "R8 rsp addr idx1", dev_rsp_addr, RSPBASE + 64'd4);
    post(1'b0, 1'b0, "R9 no msi when nonempty");
    hwrite(12'h8, 2);
    post(1'b0, 1'b1, "R9 msi after host drain");
  endtask

  task automatic t_force();
    cfg_force_msi_en = 1'b0;
    post(1'b1, 1'b0, "R10 force ignored when disabled");
    cfg_force_msi_en = 1'b1;
    post(1'b1, 1'b1, "R10 force honoured");
    post(1'b0, 1'b0, "R10 no force no msi");
  endtask

  task automatic t_full();
    post(1'b0, 1'b0, "R6 post to idx7");
    post(1'b0, 1'b0, "R11 rsp tail wrap");
    chk(dev_rsp_addr === RSPBASE, "R11 rsp addr at 0", dev_rsp_addr, RSPBASE);
    post(1'b0, 1'b0, "R6 last free slot");
    chk(dev_rsp_ready === 1'b0, "R6 full", 64'(dev_rsp_ready), 0);
    post(1'b1, 1'b0, "R6 stalled forced post no msi");
    hread(12'hC, 1, "R6 stalled post ignored");
    hwrite(12'h8, 3);
    chk(dev_rsp_ready === 1'b1, "R6 ready after drain", 64'(dev_rsp_ready), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_host_write();
    t_ro_write();
    t_req_consume();
    t_rsp_msi();
    t_force();
    t_full();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule